// File: doc/BRIEF.md
# Banked-Flag Return Stack

This block keeps the return addresses of a small 8-bit processor core in a private stack that is not reachable from the data address space. A subroutine call, an interrupt entry or a non-maskable interrupt entry pushes the 12-bit program counter supplied by the core. A subroutine return or an interrupt return pops the newest entry and hands it back one cycle later. The stack is a parameter and is meant to be built with four or six levels.

The core has only two status bits, carry and zero. Instead of saving them on the stack, the block holds one copy of the pair for each of three processor modes: normal, interrupt and non-maskable. Whichever copy belongs to the current mode is the one the core sees and the one the ALU write-back updates. Entering an interrupt or a non-maskable interrupt switches the selected copy. An interrupt return brings back the mode that was active when the popped entry was pushed, and with it that mode's flags. Each stack entry records that mode, so nested entries unwind in order.

A push on a full stack and a pop on an empty stack are refused and reported through sticky indicators that only reset clears.

Top module: `hwstack_banked`

## Requirements
- R1: A synchronous active-high reset empties the stack (level 0), selects normal mode (mode code 0), clears carry and zero in all three banks, and clears the overflow and underflow indicators and the pop-valid output.
- R2: An accepted call, interrupt entry or non-maskable entry stores save_pc and raises level by one. A return or interrupt return drives the most recently stored address on ret_pc with ret_valid high in the cycle after the request, so entries come back in last-in first-out order. ret_valid is low in every cycle that does not follow a pop request.
- R3: A push request while level equals DEPTH stores nothing, leaves level, mode and the stored entries unchanged, and sets ovf. ovf then stays high until reset.
- R4: A pop request while level is 0 returns ret_pc = 0 with ret_valid high, leaves level and mode unchanged, and sets udf. udf then stays high until reset.
- R5: An interrupt entry is accepted only in normal mode and moves the mode to interrupt (code 1). In interrupt or non-maskable mode the request is ignored: no push and no change of level or mode.
- R6: A non-maskable entry is accepted in normal or interrupt mode and moves the mode to non-maskable (code 2). In non-maskable mode the request is ignored.
- R7: An interrupt return restores the mode that was current when the popped entry was pushed. A plain return leaves the mode unchanged.
- R8: When flag_wr is high, c_in and z_in are written into the bank of the mode current in that cycle. The banks of the other two modes keep their values.
- R9: c_out and z_out always show the bank of the current mode. After a mode change they show the new mode's bank from the cycle that follows.
- R10: When several requests are high together, only the highest one is considered: non-maskable entry, then interrupt entry, then call, then interrupt return, then return. If that request is ignored under R5 or R6, the cycle has no stack or mode effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Subroutine call: push save_pc |
| ret_req | input | 1 | Subroutine return: pop address only |
| irq_req | input | 1 | Interrupt entry: push save_pc, go to interrupt mode |
| nmi_req | input | 1 | Non-maskable entry: push save_pc, go to non-maskable mode |
| reti_req | input | 1 | Interrupt return: pop address and restore mode |
| save_pc | input | PC_W | Return address to store |
| flag_wr | input | 1 | Write c_in and z_in into the current mode's bank |
| c_in | input | 1 | Carry value from the ALU |
| z_in | input | 1 | Zero value from the ALU |
| ret_pc | output | PC_W | Popped return address (registered) |
| ret_valid | output | 1 | ret_pc updated by a pop in the previous cycle |
| c_out | output | 1 | Carry of the current mode's bank |
| z_out | output | 1 | Zero of the current mode's bank |
| mode_o | output | 2 | Current mode: 0 normal, 1 interrupt, 2 non-maskable |
| level | output | clog2(DEPTH+1) | Number of stored entries |
| ovf | output | 1 | Sticky overflow indicator |
| udf | output | 1 | Sticky underflow indicator |

## Verification
The bench goes after nested unwinding: an interrupt preempted by a non-maskable entry must return first to interrupt mode and then to normal mode. A design that kept only one saved mode would land in normal mode too early and show the wrong flags. Flag isolation is probed by writing different values in each mode and reading them back after returns; a design that wrote the bank selected after the edge, or shared banks, would show leaked values. The full and empty edges are driven directly. An overflowing push must not overwrite the top entry, which the following pops would expose, and an underflowing pop must return zero without wrapping level. Simultaneous requests and ignored interrupt requests expose a wrong priority order or an acceptance rule that lets a masked entry push an address.

// File: rtl/hwstack_pkg.sv
package hwstack_pkg;

  localparam int NMODES = 3;

  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_IRQ  = 2'd1,
    MODE_NMI  = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_CALL = 3'd1,
    OP_IRQ  = 3'd2,
    OP_NMI  = 3'd3,
    OP_RET  = 3'd4,
    OP_RETI = 3'd5
  } op_e;

endpackage

// File: rtl/hwstack_lifo.sv
// Return-address storage: one write port, registered read, sticky edge errors.
module hwstack_lifo #(
  parameter int W     = 12,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 wdata,
  output logic [W-1:0]                 rdata,
  output logic                         rvalid,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic                         full,
  output logic                         empty,
  output logic                         ovf,
  output logic                         udf
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_m1;
  logic [AW-1:0] wr_idx;
  logic [AW-1:0] rd_idx;

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign cnt_m1 = cnt - CW'(1);
  assign wr_idx = cnt[AW-1:0];
  assign rd_idx = cnt_m1[AW-1:0];

  // storage array, no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (push && !full) begin
      cnt <= cnt + CW'(1);
    end else if (pop && !empty) begin
      cnt <= cnt_m1;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= pop;
      if (pop) rdata <= empty ? '0 : mem[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      if (push && full) ovf <= 1'b1;
      if (pop && empty) udf <= 1'b1;
    end
  end

endmodule

// File: rtl/hwstack_mode.sv
// Current processor mode plus the mode saved alongside each stack level.
module hwstack_mode
  import hwstack_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic                       pop,
  input  logic [$clog2(DEPTH+1)-1:0] cnt,
  input  logic                       go_irq,
  input  logic                       go_nmi,
  input  logic                       restore,
  output mode_e                      mode_q
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  mode_e         saved [DEPTH];
  logic [CW-1:0] cnt_m1;
  logic [AW-1:0] wr_idx;
  logic [AW-1:0] rd_idx;

  assign cnt_m1 = cnt - CW'(1);
  assign wr_idx = cnt[AW-1:0];
  assign rd_idx = cnt_m1[AW-1:0];

  // small side array in flops: read combinationally so the mode
  // switches on the same edge as the pop
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) saved[i] <= MODE_NORM;
    end else if (push) begin
      saved[wr_idx] <= mode_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_NORM;
    end else if (go_nmi) begin
      mode_q <= MODE_NMI;
    end else if (go_irq) begin
      mode_q <= MODE_IRQ;
    end else if (restore && pop) begin
      mode_q <= saved[rd_idx];
    end
  end

endmodule

// File: rtl/hwstack_flags.sv
// One carry/zero pair per mode; the current mode selects read and write.
module hwstack_flags
  import hwstack_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr,
  input  mode_e sel,
  input  logic  c_in,
  input  logic  z_in,
  output logic  c_out,
  output logic  z_out
);
  logic bank_c [NMODES];
  logic bank_z [NMODES];

  for (genvar m = 0; m < NMODES; m++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_c[m] <= 1'b0;
        bank_z[m] <= 1'b0;
      end else if (wr && (sel == mode_e'(m))) begin
        bank_c[m] <= c_in;
        bank_z[m] <= z_in;
      end
    end
  end

  always_comb begin
    c_out = 1'b0;
    z_out = 1'b0;
    for (int m = 0; m < NMODES; m++) begin
      if (sel == mode_e'(m)) begin
        c_out = bank_c[m];
        z_out = bank_z[m];
      end
    end
  end

endmodule

// File: rtl/hwstack_banked.sv
// Return-address stack with mode-banked carry/zero flags.
module hwstack_banked
  import hwstack_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       call_req,
  input  logic                       ret_req,
  input  logic                       irq_req,
  input  logic                       nmi_req,
  input  logic                       reti_req,
  input  logic [PC_W-1:0]            save_pc,
  input  logic                       flag_wr,
  input  logic                       c_in,
  input  logic                       z_in,
  output logic [PC_W-1:0]            ret_pc,
  output logic                       ret_valid,
  output logic                       c_out,
  output logic                       z_out,
  output logic [1:0]                 mode_o,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       ovf,
  output logic                       udf
);
  op_e   op;
  mode_e mode;
  logic  push_ok, pop_rq, full, empty;
  logic  go_irq, go_nmi;

  // fixed priority among simultaneous requests
  always_comb begin
    if (nmi_req)       op = OP_NMI;
    else if (irq_req)  op = OP_IRQ;
    else if (call_req) op = OP_CALL;
    else if (reti_req) op = OP_RETI;
    else if (ret_req)  op = OP_RET;
    else               op = OP_NONE;
  end

  // acceptance depends on the mode in force before the edge
  assign push_ok = (op == OP_CALL) ||
                   ((op == OP_IRQ) && (mode == MODE_NORM)) ||
                   ((op == OP_NMI) && (mode != MODE_NMI));
  assign pop_rq  = (op == OP_RET) || (op == OP_RETI);
  assign go_irq  = (op == OP_IRQ) && (mode == MODE_NORM) && !full;
  assign go_nmi  = (op == OP_NMI) && (mode != MODE_NMI) && !full;

  hwstack_lifo #(
    .W     (PC_W),
    .DEPTH (DEPTH)
  ) u_lifo (
    .clk    (clk),
    .rst    (rst),
    .push   (push_ok),
    .pop    (pop_rq),
    .wdata  (save_pc),
    .rdata  (ret_pc),
    .rvalid (ret_valid),
    .cnt    (level),
    .full   (full),
    .empty  (empty),
    .ovf    (ovf),
    .udf    (udf)
  );

  hwstack_mode #(
    .DEPTH (DEPTH)
  ) u_mode (
    .clk     (clk),
    .rst     (rst),
    .push    (push_ok && !full),
    .pop     (pop_rq && !empty),
    .cnt     (level),
    .go_irq  (go_irq),
    .go_nmi  (go_nmi),
    .restore (op == OP_RETI),
    .mode_q  (mode)
  );

  hwstack_flags u_flags (
    .clk   (clk),
    .rst   (rst),
    .wr    (flag_wr),
    .sel   (mode),
    .c_in  (c_in),
    .z_in  (z_in),
    .c_out (c_out),
    .z_out (z_out)
  );

  assign mode_o = mode;

endmodule

// File: rtl/hwstack_banked_chk.sv
module hwstack_banked_chk #(
  parameter int PC_W  = 12,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       call_req,
  input logic                       ret_req,
  input logic                       irq_req,
  input logic                       nmi_req,
  input logic                       reti_req,
  input logic                       flag_wr,
  input logic [PC_W-1:0]            ret_pc,
  input logic                       ret_valid,
  input logic                       c_out,
  input logic                       z_out,
  input logic [1:0]                 mode_o,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic                       ovf,
  input logic                       udf
);
  localparam int CW = $clog2(DEPTH + 1);

  logic any_req;
  logic pop_only;
  assign any_req  = call_req | ret_req | irq_req | nmi_req | reti_req;
  assign pop_only = (ret_req | reti_req) & ~call_req & ~irq_req & ~nmi_req;

  // R1
  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (level == '0) && (mode_o == 2'd0) && !ovf && !udf && !ret_valid);

  // R2
  a_r2_pop_valid: assert property (@(posedge clk) disable iff (rst)
    pop_only |=> ret_valid);
  a_r2_no_pop_quiet: assert property (@(posedge clk) disable iff (rst)
    !pop_only |=> !ret_valid);

  // R3
  a_r3_full_holds: assert property (@(posedge clk) disable iff (rst)
    (level == CW'(DEPTH)) && call_req |=> level == CW'(DEPTH));
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  // R4
  a_r4_empty_pop_zero: assert property (@(posedge clk) disable iff (rst)
    (level == '0) && pop_only |=> (ret_pc == '0) && udf && (level == '0));
  a_r4_udf_sticky: assert property (@(posedge clk) disable iff (rst)
    udf |=> udf);

  // R5
  a_r5_irq_entry_cause: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd1) && ($past(mode_o) != 2'd1) |-> $past(irq_req) || $past(reti_req));

  // R6
  a_r6_nmi_entry_cause: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2) && ($past(mode_o) != 2'd2) |-> $past(nmi_req) || $past(reti_req));

  // R7
  a_r7_ret_keeps_mode: assert property (@(posedge clk) disable iff (rst)
    ret_req && !reti_req && !call_req && !irq_req && !nmi_req |=> $stable(mode_o));

  // R8, R9
  a_r8_flags_idle: assert property (@(posedge clk) disable iff (rst)
    !flag_wr && !any_req |=> $stable(c_out) && $stable(z_out));

endmodule

bind hwstack_banked hwstack_banked_chk #(
  .PC_W  (PC_W),
  .DEPTH (DEPTH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .call_req  (call_req),
  .ret_req   (ret_req),
  .irq_req   (irq_req),
  .nmi_req   (nmi_req),
  .reti_req  (reti_req),
  .flag_wr   (flag_wr),
  .ret_pc    (ret_pc),
  .ret_valid (ret_valid),
  .c_out     (c_out),
  .z_out     (z_out),
  .mode_o    (mode_o),
  .level     (level),
  .ovf       (ovf),
  .udf       (udf)
);

// File: tb/tb_hwstack_banked.sv
module tb_hwstack_banked;
  localparam int PERIOD = 10;
  localparam int PC_W   = 12;
  localparam int DEPTH  = 4;
  localparam int CW     = $clog2(DEPTH + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            call_req = 0, ret_req = 0, irq_req = 0, nmi_req = 0, reti_req = 0;
  logic [PC_W-1:0] save_pc = '0;
  logic            flag_wr = 0, c_in = 0, z_in = 0;
  logic [PC_W-1:0] ret_pc;
  logic            ret_valid, c_out, z_out, ovf, udf;
  logic [1:0]      mode_o;
  logic [CW-1:0]   level;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  int       m_cnt, m_mode, m_rpc, m_rv, m_ovf, m_udf;
  int       m_pc [DEPTH];
  int       m_md [DEPTH];
  bit       m_bc [3];
  bit       m_bz [3];

  always #(PERIOD/2) clk = ~clk;

  hwstack_banked #(.PC_W(PC_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .call_req(call_req), .ret_req(ret_req),
    .irq_req(irq_req), .nmi_req(nmi_req), .reti_req(reti_req),
    .save_pc(save_pc), .flag_wr(flag_wr), .c_in(c_in), .z_in(z_in),
    .ret_pc(ret_pc), .ret_valid(ret_valid), .c_out(c_out), .z_out(z_out),
    .mode_o(mode_o), .level(level), .ovf(ovf), .udf(udf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_mode = 0; m_rpc = 0; m_rv = 0; m_ovf = 0; m_udf = 0;
    for (int i = 0; i < 3; i++) begin m_bc[i] = 0; m_bz[i] = 0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; call_req = 0; ret_req = 0; irq_req = 0; nmi_req = 0; reti_req = 0;
    flag_wr = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  task automatic compare_all();
    chk("R2 ret_valid", int'(ret_valid), m_rv);
    if (m_rv != 0) chk("R2 ret_pc", int'(ret_pc), m_rpc);
    chk("R3 level", int'(level), m_cnt);
    chk("R3 ovf", int'(ovf), m_ovf);
    chk("R4 udf", int'(udf), m_udf);
    chk("R7 mode", int'(mode_o), m_mode);
    chk("R9 c_out", int'(c_out), int'(m_bc[m_mode]));
    chk("R9 z_out", int'(z_out), int'(m_bz[m_mode]));
  endtask

  // one cycle of stimulus, model update and comparison
  task automatic step(input bit c, input bit r, input bit i, input bit n, input bit ri,
                      input int pc, input bit fw, input bit fc, input bit fz);
    int op, old, push;
    @(negedge clk);
    call_req = c; ret_req = r; irq_req = i; nmi_req = n; reti_req = ri;
    save_pc = PC_W'(pc); flag_wr = fw; c_in = fc; z_in = fz;
    @(posedge clk);
    #(PERIOD/4);
    if (n) op = 3; else if (i) op = 2; else if (c) op = 1;
    else if (ri) op = 5; else if (r) op = 4; else op = 0;
    old  = m_mode;
    push = (op == 1) || (op == 2 && m_mode == 0) || (op == 3 && m_mode != 2);
    m_rv = 0;
    if (fw) begin m_bc[old] = fc; m_bz[old] = fz; end
    if (push) begin
      if (m_cnt == DEPTH) m_ovf = 1;
      else begin
        m_pc[m_cnt] = pc & 12'hfff; m_md[m_cnt] = m_mode; m_cnt++;
        if (op == 2) m_mode = 1;
        if (op == 3) m_mode = 2;
      end
    end
    if (op == 4 || op == 5) begin
      m_rv = 1;
      if (m_cnt == 0) begin m_rpc = 0; m_udf = 1; end
      else begin
        m_cnt--; m_rpc = m_pc[m_cnt];
        if (op == 5) m_mode = m_md[m_cnt];
      end
    end
    compare_all();
  endtask

  task automatic idle(); step(0,0,0,0,0, 0, 0,0,0); endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    do_reset();
    #(PERIOD/4);
    // R1 reset state
    chk("R1 level", int'(level), 0);
    chk("R1 mode", int'(mode_o), 0);
    chk("R1 flags", int'({c_out, z_out}), 0);
    chk("R1 ovf/udf", int'({ovf, udf}), 0);
    chk("R1 ret_valid", int'(ret_valid), 0);

    // normal-mode flags, then calls and returns in LIFO order (R2)
    step(0,0,0,0,0, 0, 1,1,0);
    step(1,0,0,0,0, 'h123, 0,0,0);
    step(1,0,0,0,0, 'h456, 0,0,0);
    step(0,1,0,0,0, 0, 0,0,0);
    chk("R2 lifo first pop", int'(ret_pc), 'h456);
    step(0,1,0,0,0, 0, 0,0,0);
    chk("R2 lifo second pop", int'(ret_pc), 'h123);
    idle();
    chk("R2 valid drops", int'(ret_valid), 0);

    // underflow (R4)
    step(0,1,0,0,0, 0, 0,0,0);
    chk("R4 empty pop zero", int'(ret_pc), 0);
    chk("R4 udf set", int'(udf), 1);

    // nesting and banks (R5 R6 R7 R8)
    do_reset();
    step(0,0,0,0,0, 0, 1,1,0);
    step(0,0,1,0,0, 'habc, 0,0,0);
    chk("R5 irq entry mode", int'(mode_o), 1);
    chk("R9 irq bank clear", int'({c_out, z_out}), 0);
    step(0,0,0,0,0, 0, 1,0,1);
    step(0,0,1,0,0, 'h111, 0,0,0);
    chk("R5 irq in irq ignored", int'(level), 1);
    step(0,0,0,1,0, 'h777, 0,0,0);
    chk("R6 nmi preempts irq", int'(mode_o), 2);
    step(0,0,0,0,0, 0, 1,1,1);
    step(0,0,0,1,0, 'h222, 0,0,0);
    chk("R6 nmi in nmi ignored", int'(level), 2);
    step(0,0,1,0,0, 'h333, 0,0,0);
    chk("R5 irq in nmi ignored", int'(level), 2);
    step(0,0,0,0,1, 0, 0,0,0);
    chk("R7 reti to irq", int'(mode_o), 1);
    chk("R8 irq bank kept", int'({c_out, z_out}), 1);
    step(0,0,0,0,1, 0, 0,0,0);
    chk("R7 reti to normal", int'(mode_o), 0);
    chk("R8 normal bank kept", int'({c_out, z_out}), 2);
    chk("R2 reti address", int'(ret_pc), 'habc);

    // overflow keeps contents (R3)
    do_reset();
    for (int k = 0; k < DEPTH; k++) step(1,0,0,0,0, 'h100 + k, 0,0,0);
    step(1,0,0,0,0, 'hfff, 0,0,0);
    chk("R3 ovf on full", int'(ovf), 1);
    step(0,0,0,1,0, 'hfff, 0,0,0);
    chk("R3 full nmi no mode change", int'(mode_o), 0);
    step(0,1,0,0,0, 0, 0,0,0);
    chk("R3 top entry intact", int'(ret_pc), 'h100 + DEPTH - 1);
    for (int k = 0; k < DEPTH - 1; k++) step(0,1,0,0,0, 0, 0,0,0);
    chk("R3 ovf sticky", int'(ovf), 1);

    // priority (R10)
    do_reset();
    step(1,1,1,1,1, 'h5a5, 0,0,0);
    chk("R10 nmi wins", int'(mode_o), 2);
    chk("R10 single push", int'(level), 1);
    step(1,0,1,0,0, 'h0aa, 0,0,0);
    chk("R10 ignored irq blocks call", int'(level), 1);
    step(0,1,0,0,1, 0, 0,0,0);
    chk("R10 reti over ret", int'(mode_o), 0);

    // constrained random traffic
    do_reset();
    for (int s = 0; s < 4000; s++) begin
      int r, pc;
      bit c, rt, i, n, ri, fw;
      r = int'($urandom % 16);
      pc = int'($urandom % 4096);
      fw = ($urandom % 3) == 0;
      c = 0; rt = 0; i = 0; n = 0; ri = 0;
      if (r < 4) c = 1;
      else if (r < 7) rt = 1;
      else if (r == 7) i = 1;
      else if (r == 8) n = 1;
      else if (r < 11) ri = 1;
      else if (r == 11) begin
        c = $urandom % 2; rt = $urandom % 2; i = $urandom % 2;
        n = $urandom % 2; ri = $urandom % 2;
      end
      step(c, rt, i, n, ri, pc, fw, 1'($urandom), 1'($urandom));
      if (s % 700 == 699) do_reset();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule